// File: doc/BRIEF.md
# Bit-masked GPIO control register bank

This block holds the control state of a 32-pin general-purpose I/O port: one register that sets the level each pin drives, and one register that chooses, pin by pin, whether the pin drives or listens. Each 32-bit register is reached as two word addresses, one for the low sixteen pins and one for the high sixteen. Every bus write carries its own 16-bit enable mask in the upper half of the word. Only the data bits whose enable is set change, so software can flip a single pin without first reading the register.

Two read-only words complete the map. One returns the live input levels of all 32 pins. The other returns a fixed identification word. Reads are registered: the read word appears on the cycle after the read strobe and stays there until the next read.

Top module: `gpio_hwm_regs`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, pin_out, pin_oe and bus_rdata are all zero.
- R2: A write to byte address 0x00 updates pin_out[15:0]. Bit i takes bus_wdata[i] when bus_wdata[i+16] is 1. It keeps its previous value when bus_wdata[i+16] is 0. The change is visible on the cycle after the write.
- R3: A write to byte address 0x04 updates pin_out[31:16] under the same masking rule, with pin_out[16+i] governed by bus_wdata[i] and bus_wdata[i+16]. It leaves pin_out[15:0] unchanged.
- R4: A single pin is set by a write that carries both its data bit and its enable bit, and cleared by a write that carries only its enable bit. Every other pin keeps its value.
- R5: A read of a half-register returns that half in bus_rdata[15:0], with zeros in bus_rdata[31:16], on the cycle after bus_rd. bus_rdata holds its value while bus_rd is low.
- R6: Addresses 0x08 and 0x0C hold the direction register, low half and high half, under the same masking rule. pin_oe[i] equal to 1 makes pin i an output. pin_oe[i] equal to 0 makes it an input. The enable bits are never stored.
- R7: A read of address 0x14 returns VERSION_ID, which holds the major version in [31:24], the minor version in [23:16] and the revision in [15:0]. A write to that address changes neither pin_out, pin_oe nor the value read back.
- R8: A read of address 0x10 returns pin_in as it stands in the cycle of the read strobe, all 32 bits.
- R9: When a read and a write to the same half-register fall in the same cycle, the read returns the value from before the write, and the write still takes effect.
- R10: A write to an unmapped word, or to an address whose two low bits are not zero, changes nothing. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write word: [15:0] data, [31:16] per-bit enable |
| bus_rdata | output | 32 | Registered read word |
| pin_in | input | 32 | Live pin levels |
| pin_out | output | 32 | Level driven on each pin |
| pin_oe | output | 32 | Per-pin output enable (1 = output) |

## Verification
A read and a masked write can land on the same half-register in the same cycle. The bench provokes this by raising both strobes together on address 0x00. It expects the old contents on bus_rdata and the new contents on pin_out one cycle later. A behavioural model checks the same collision on every cycle of a long random stretch, in which reads and writes to any mapped or unmapped word overlap freely.

// File: rtl/gpio_hwm_pkg.sv
package gpio_hwm_pkg;
  localparam int HALF_W = 16;            // data bits per bus write
  localparam int NHALF  = 2;             // halves per control register
  localparam int DATA_W = HALF_W * NHALF;
  localparam int NREG   = 2;             // 0: output level, 1: direction
  localparam int REG_OUT = 0;
  localparam int REG_DIR = 1;
  localparam int PORT_IDX = NREG * NHALF; // live pin word
  localparam int VER_IDX  = PORT_IDX + 1; // identification word
  localparam int NWORD    = VER_IDX + 1;
endpackage

// File: rtl/gpio_hwm_half.sv
module gpio_hwm_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] data,
  input  logic [W-1:0] en,
  output logic [W-1:0] q
);
  // Each bit is updated only where its enable bit is set.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= (q & ~en) | (data & en);
    end
  end
endmodule

// File: rtl/gpio_hwm_rdmux.sv
module gpio_hwm_rdmux
  import gpio_hwm_pkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION_ID = 32'h0203_0041
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd,
  input  logic [NWORD-1:0]                 sel,
  input  logic [NREG-1:0][DATA_W-1:0]      ctl,
  input  logic [DATA_W-1:0]                pin_in,
  output logic [DATA_W-1:0]                rdata
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int r = 0; r < NREG; r++) begin
      for (int h = 0; h < NHALF; h++) begin
        if (sel[r*NHALF+h]) begin
          nxt = {{(DATA_W-HALF_W){1'b0}}, ctl[r][h*HALF_W +: HALF_W]};
        end
      end
    end
    if (sel[PORT_IDX]) nxt = pin_in;
    if (sel[VER_IDX])  nxt = VERSION_ID;
  end

  // Registered read: samples state before any write of the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= nxt;
    end
  end
endmodule

// File: rtl/gpio_hwm_regs.sv
module gpio_hwm_regs
  import gpio_hwm_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [DATA_W-1:0] VERSION_ID = 32'h0203_0041
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe
);
  localparam int WORD_W = ADDR_W - 2;

  logic                        aligned;
  logic [WORD_W-1:0]           word;
  logic [NWORD-1:0]            sel;
  logic [NREG-1:0][DATA_W-1:0] ctl_q;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign word    = bus_addr[ADDR_W-1:2];

  for (genvar i = 0; i < NWORD; i++) begin : g_dec
    assign sel[i] = aligned && (word == WORD_W'(i));
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar h = 0; h < NHALF; h++) begin : g_half
      gpio_hwm_half #(.W(HALF_W)) u_half (
        .clk  (clk),
        .rst  (rst),
        .we   (bus_wr && sel[r*NHALF+h]),
        .data (bus_wdata[HALF_W-1:0]),
        .en   (bus_wdata[DATA_W-1:HALF_W]),
        .q    (ctl_q[r][h*HALF_W +: HALF_W])
      );
    end
  end

  assign pin_out = ctl_q[REG_OUT];
  assign pin_oe  = ctl_q[REG_DIR];

  gpio_hwm_rdmux #(.VERSION_ID(VERSION_ID)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .sel    (sel),
    .ctl    (ctl_q),
    .pin_in (pin_in),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/gpio_hwm_chk.sv
module gpio_hwm_chk #(
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] VERSION_ID = 32'h0203_0041
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       pin_out,
  input logic [31:0]       pin_oe
);
  logic wr_lo, wr_hi, rd_half, rd_ver, wr_ver;
  assign wr_lo   = bus_wr && (bus_addr == ADDR_W'(8'h00));
  assign wr_hi   = bus_wr && (bus_addr == ADDR_W'(8'h04));
  assign rd_half = bus_rd && (bus_addr[1:0] == 2'b00) && (bus_addr < ADDR_W'(8'h10));
  assign rd_ver  = bus_rd && (bus_addr == ADDR_W'(8'h14));
  assign wr_ver  = bus_wr && (bus_addr == ADDR_W'(8'h14));

  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> (pin_out == 32'h0 && pin_oe == 32'h0 && bus_rdata == 32'h0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !$past(bus_wr) |-> ($stable(pin_out) && $stable(pin_oe))); // R2
  AST_MASKED_LO: assert property (@(posedge clk) disable iff (rst) $past(wr_lo) |-> (pin_out[15:0] == (($past(pin_out[15:0]) & ~$past(bus_wdata[31:16])) | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))))); // R2
  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst) $past(wr_hi) |-> (pin_out[15:0] == $past(pin_out[15:0]))); // R3
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) $past(rd_half) |-> (bus_rdata[31:16] == 16'h0)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !$past(bus_rd) |-> $stable(bus_rdata)); // R5
  AST_VERSION: assert property (@(posedge clk) disable iff (rst) $past(rd_ver) |-> (bus_rdata == VERSION_ID)); // R7
  AST_VER_WRITE_NOP: assert property (@(posedge clk) disable iff (rst) $past(wr_ver) |-> ($stable(pin_out) && $stable(pin_oe))); // R7
endmodule

bind gpio_hwm_regs gpio_hwm_chk #(.ADDR_W(ADDR_W), .VERSION_ID(VERSION_ID)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_gpio_hwm_regs.sv
`timescale 1ns/1ps
module sim_gpio_hwm_regs;
  localparam int ADDR_W = 8;
  localparam logic [31:0] VER = 32'h0203_0041;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  gpio_hwm_regs #(.ADDR_W(ADDR_W), .VERSION_ID(VER)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_out = '0, m_dir = '0, m_rd = '0;
  always @(posedge clk) begin
    logic [15:0] d, e;
    int a;
    d = bus_wdata[15:0];
    e = bus_wdata[31:16];
    a = int'(bus_addr);
    if (rst) begin
      m_out = '0; m_dir = '0; m_rd = '0;
    end else begin
      if (bus_rd) begin
        case (a)
          0: m_rd = {16'h0, m_out[15:0]};
          4: m_rd = {16'h0, m_out[31:16]};
          8: m_rd = {16'h0, m_dir[15:0]};
          12: m_rd = {16'h0, m_dir[31:16]};
          16: m_rd = pin_in;
          20: m_rd = VER;
          default: m_rd = 32'h0;
        endcase
      end
      if (bus_wr) begin
        for (int i = 0; i < 16; i++) begin
          if (e[i]) begin
            case (a)
              0: m_out[i] = d[i];
              4: m_out[i+16] = d[i];
              8: m_dir[i] = d[i];
              12: m_dir[i+16] = d[i];
              default: ;
            endcase
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    chk(tag, "model pin_out", pin_out, m_out);
    chk(tag, "model pin_oe", pin_oe, m_dir);
    chk(tag, "model rdata", bus_rdata, m_rd);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic op(input logic w, input logic r, input logic [ADDR_W-1:0] a, input logic [31:0] dat);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = dat;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset pin_out", pin_out, 32'h0);
    chk("R1", "reset pin_oe", pin_oe, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset rdata", bus_rdata, 32'h0);

    tag = "R2";
    op(1, 0, 8'h00, 32'hFFFF_A5C3);
    chk("R2", "full low write", pin_out, 32'h0000_A5C3);
    op(1, 0, 8'h00, 32'h00F0_0000);
    chk("R2", "masked clear 7:4", pin_out, 32'h0000_A503);
    op(1, 0, 8'h00, 32'h0000_FFFF);
    chk("R2", "no-enable write", pin_out, 32'h0000_A503);

    tag = "R3";
    op(1, 0, 8'h04, 32'h8001_8001);
    chk("R3", "high half write", pin_out, 32'h8001_A503);

    tag = "R4";
    op(1, 0, 8'h04, 32'h0010_0010);
    chk("R4", "set pin 20", pin_out, 32'h8011_A503);
    op(1, 0, 8'h00, 32'h0001_0000);
    chk("R4", "clear pin 0", pin_out, 32'h8011_A502);

    tag = "R6";
    op(1, 0, 8'h08, 32'hFFFF_00FF);
    chk("R6", "dir low", pin_oe, 32'h0000_00FF);
    op(1, 0, 8'h0C, 32'h0F00_0F00);
    chk("R6", "dir high", pin_oe, 32'h0F00_00FF);
    chk("R6", "dir leaves out", pin_out, 32'h8011_A502);

    tag = "R5";
    op(0, 1, 8'h00, 32'h0);
    chk("R5", "read out low", bus_rdata, 32'h0000_A502);
    op(0, 1, 8'h04, 32'h0);
    chk("R5", "read out high", bus_rdata, 32'h0000_8011);
    op(0, 1, 8'h0C, 32'h0);
    chk("R5", "read dir high", bus_rdata, 32'h0000_0F00);
    repeat (2) @(negedge clk);
    chk("R5", "rdata held", bus_rdata, 32'h0000_0F00);

    tag = "R8";
    pin_in = 32'hDEAD_BEEF;
    op(0, 1, 8'h10, 32'h0);
    chk("R8", "port read 1", bus_rdata, 32'hDEAD_BEEF);
    pin_in = 32'h1357_9BDF;
    op(0, 1, 8'h10, 32'h0);
    chk("R8", "port read 2", bus_rdata, 32'h1357_9BDF);

    tag = "R7";
    op(0, 1, 8'h14, 32'h0);
    chk("R7", "version", bus_rdata, VER);
    op(1, 0, 8'h14, 32'hFFFF_FFFF);
    op(0, 1, 8'h14, 32'h0);
    chk("R7", "version after write", bus_rdata, VER);
    chk("R7", "out after ver write", pin_out, 32'h8011_A502);
    chk("R7", "oe after ver write", pin_oe, 32'h0F00_00FF);

    tag = "R9";
    op(1, 1, 8'h00, 32'hFFFF_1234);
    chk("R9", "collide read old", bus_rdata, 32'h0000_A502);
    chk("R9", "collide write new", pin_out, 32'h8011_1234);

    tag = "R10";
    op(1, 0, 8'h1C, 32'hFFFF_FFFF);
    op(1, 0, 8'h01, 32'hFFFF_FFFF);
    op(1, 0, 8'h09, 32'hFFFF_FFFF);
    chk("R10", "unmapped out", pin_out, 32'h8011_1234);
    chk("R10", "unmapped oe", pin_oe, 32'h0F00_00FF);
    op(0, 1, 8'h1C, 32'h0);
    chk("R10", "unmapped read", bus_rdata, 32'h0);
    op(0, 1, 8'h05, 32'h0);
    chk("R10", "misaligned read", bus_rdata, 32'h0);

    tag = "R2";
    for (int n = 0; n < 400; n++) begin
      logic [2:0] pick;
      @(negedge clk);
      pick = 3'($urandom_range(0, 7));
      bus_addr = (pick == 3'd6) ? 8'h1C : (pick == 3'd7) ? 8'h02 : {3'b0, pick, 2'b00};
      bus_wr = 1'($urandom_range(0, 1));
      bus_rd = 1'($urandom_range(0, 1));
      bus_wdata = $urandom;
      pin_in = $urandom;
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule